// File: doc/BRIEF.md
# Divided Memory Clock Generator with Burst Latency Counter

This block derives the clock for an external synchronous memory from the system clock. A programmable integer ratio sets how many system-clock cycles make up one memory-clock period. The memory clock always begins with its low phase. For odd ratios the low phase takes the extra system cycle.

Two run policies exist. In gated operation the memory clock toggles only while a synchronous access is requested. When continuous operation is enabled and the primary bank is flagged as synchronous, the clock free-runs regardless of requests. Continuous operation requested while that bank is not synchronous degrades to gated operation.

Alongside the clock, the block produces one-cycle strobes marking each rising and falling memory-clock edge. It also counts a programmable initial latency, measured in memory-clock cycles, and raises a single-cycle pulse when the first beat of a burst is due.

Top module: `mem_clk_gen`

## Requirements
- R1: While `rst_n` is low, `mem_clk`, `rise_stb`, `fall_stb` and `first_data` are all 0.
- R2: With `cont_en` = 0, `mem_clk` stays at 0 while `sync_req` = 0. Asserting `sync_req` starts it toggling.
- R3: With `cont_en` = 1 and `bank_sync` = 1, `mem_clk` toggles even while `sync_req` = 0.
- R4: With `cont_en` = 1 but `bank_sync` = 0, the clock behaves as in gated operation and stays at 0 without `sync_req`.
- R5: The ratio N is `div_ratio` saturated into 2..16 (0 and 1 give 2, values above 16 give 16). Each memory-clock period has a high phase of floor(N/2) system cycles and a low phase of ceil(N/2) system cycles. A start from idle begins with a full low phase.
- R6: When the run condition drops, the clock halts only at a period boundary. A high phase that has begun lasts its full floor(N/2) cycles, and `mem_clk` then stays 0.
- R7: `rise_stb` is 1 exactly in the system cycles where `mem_clk` is 1 after being 0 in the previous cycle. `fall_stb` is 1 exactly where `mem_clk` is 0 after being 1. The two are never 1 together.
- R8: The latency L is `latency` saturated into 2..17. Counting starts at the first memory-clock rising edge seen while `sync_req` = 1, which is rising edge number 1. `first_data` pulses for one system cycle together with `rise_stb` at rising edge number L+1. It pulses once per request.
- R9: A new `div_ratio` value written in mid-period does not alter the current period. It governs the periods that start after the next period boundary.
- R10: `first_data` is 0 in any cycle that follows a cycle with `sync_req` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_ratio | input | DIV_W (5) | System cycles per memory-clock period, saturated to 2..16 |
| latency | input | LAT_W (5) | Initial latency in memory-clock cycles, saturated to 2..17 |
| cont_en | input | 1 | Request free-running clock |
| bank_sync | input | 1 | Primary bank is in synchronous mode (permits free-running clock) |
| sync_req | input | 1 | Synchronous read or write in progress |
| mem_clk | output | 1 | Divided memory clock |
| rise_stb | output | 1 | One-cycle strobe on each memory-clock rising edge |
| fall_stb | output | 1 | One-cycle strobe on each memory-clock falling edge |
| first_data | output | 1 | One-cycle pulse when the first burst beat is due |

## Verification
The bench builds the block with its default parameters: ratio range 2..16, latency range 2..17, 5-bit fields, and the free-running variant included. The 5-bit fields let the bench drive 0 and 31, so saturation at both ends of both ranges can be reached. The 2..16 range covers the shortest period (one cycle high, one low), odd ratios with their uneven split, and the 17-cycle latency at the 16-cycle ratio, which is the longest burst start. Including the free-running variant puts the interplay of `cont_en` and `bank_sync` within reach.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

   typedef enum logic [1:0] {
      LAT_IDLE  = 2'd0,
      LAT_COUNT = 2'd1,
      LAT_DONE  = 2'd2
   } lat_state_e;

   function automatic int unsigned sat_range(input int unsigned v,
                                             input int unsigned lo,
                                             input int unsigned hi);
      if (v < lo)      return lo;
      else if (v > hi) return hi;
      else             return v;
   endfunction

endpackage

// File: rtl/mcg_sat.sv
module mcg_sat #(
   parameter int W  = 5,
   parameter int LO = 2,
   parameter int HI = 16
) (
   input  logic [W-1:0] val_in,
   output logic [W-1:0] val_out
);
   if (LO > HI || HI >= (1 << W)) begin : g_bad_range
      $error("mcg_sat: range does not fit width");
   end

   always_comb begin
      val_out = W'(mcg_pkg::sat_range(int'(val_in), LO, HI));
   end
endmodule

// File: rtl/mcg_phase.sv
module mcg_phase #(
   parameter int DW      = 5,
   parameter int RST_DIV = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          want,
   input  logic [DW-1:0] div_in,
   output logic          mem_clk,
   output logic          rise_stb,
   output logic          fall_stb,
   output logic          rise_nx
);
   logic          run_q, run_d;
   logic [DW-1:0] cnt_q, cnt_d;
   logic [DW-1:0] div_q, div_d;
   logic [DW-1:0] low_d;
   logic          clk_d;

   always_comb begin
      run_d = run_q;
      cnt_d = cnt_q;
      div_d = div_q;
      if (!run_q) begin
         if (want) begin
            run_d = 1'b1;
            cnt_d = '0;
            div_d = div_in;
         end
      end else if (cnt_q == div_q - 1'b1) begin
         cnt_d = '0;
         div_d = div_in;
         run_d = want;
      end else begin
         cnt_d = cnt_q + 1'b1;
      end
      low_d   = div_d - (div_d >> 1);
      clk_d   = run_d && (cnt_d >= low_d);
      rise_nx = clk_d && !mem_clk;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         cnt_q    <= '0;
         div_q    <= DW'(RST_DIV);
         mem_clk  <= 1'b0;
         rise_stb <= 1'b0;
         fall_stb <= 1'b0;
      end else begin
         run_q    <= run_d;
         cnt_q    <= cnt_d;
         div_q    <= div_d;
         mem_clk  <= clk_d;
         rise_stb <= clk_d && !mem_clk;
         fall_stb <= !clk_d && mem_clk;
      end
   end
endmodule

// File: rtl/mcg_latency.sv
module mcg_latency #(
   parameter int LW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_req,
   input  logic          rise_nx,
   input  logic [LW-1:0] lat_in,
   output logic          first_data
);
   import mcg_pkg::*;

   lat_state_e    st_q;
   logic [LW-1:0] cnt_q;
   logic [LW-1:0] tgt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= LAT_IDLE;
         cnt_q      <= '0;
         tgt_q      <= '0;
         first_data <= 1'b0;
      end else begin
         first_data <= 1'b0;
         unique case (st_q)
            LAT_IDLE: begin
               if (sync_req && rise_nx) begin
                  st_q  <= LAT_COUNT;
                  cnt_q <= '0;
                  tgt_q <= lat_in;
               end
            end
            LAT_COUNT: begin
               if (!sync_req) begin
                  st_q <= LAT_IDLE;
               end else if (rise_nx) begin
                  if (cnt_q + 1'b1 == tgt_q) begin
                     first_data <= 1'b1;
                     st_q       <= LAT_DONE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: begin
               if (!sync_req) st_q <= LAT_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/mem_clk_gen.sv
module mem_clk_gen #(
   parameter int MIN_DIV    = 2,
   parameter int MAX_DIV    = 16,
   parameter int MIN_LAT    = 2,
   parameter int MAX_LAT    = 17,
   parameter bit ALLOW_CONT = 1'b1,
   parameter int DIV_W      = $clog2(MAX_DIV + 1),
   parameter int LAT_W      = $clog2(MAX_LAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_ratio,
   input  logic [LAT_W-1:0] latency,
   input  logic             cont_en,
   input  logic             bank_sync,
   input  logic             sync_req,
   output logic             mem_clk,
   output logic             rise_stb,
   output logic             fall_stb,
   output logic             first_data
);
   if (MIN_DIV < 2) begin : g_bad_div
      $error("mem_clk_gen: divide ratio below 2 cannot form two phases");
   end
   if (MIN_LAT < 1) begin : g_bad_lat
      $error("mem_clk_gen: latency must be at least one cycle");
   end

   logic [DIV_W-1:0] div_sat;
   logic [LAT_W-1:0] lat_sat;
   logic             want;
   logic             rise_nx;

   mcg_sat #(.W(DIV_W), .LO(MIN_DIV), .HI(MAX_DIV)) u_div_sat (
      .val_in  (div_ratio),
      .val_out (div_sat)
   );

   mcg_sat #(.W(LAT_W), .LO(MIN_LAT), .HI(MAX_LAT)) u_lat_sat (
      .val_in  (latency),
      .val_out (lat_sat)
   );

   if (ALLOW_CONT) begin : g_cont
      assign want = sync_req || (cont_en && bank_sync);
   end else begin : g_gated
      logic unused_cfg;
      assign unused_cfg = cont_en ^ bank_sync;
      assign want       = sync_req;
   end

   mcg_phase #(.DW(DIV_W), .RST_DIV(MIN_DIV)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .want     (want),
      .div_in   (div_sat),
      .mem_clk  (mem_clk),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .rise_nx  (rise_nx)
   );

   mcg_latency #(.LW(LAT_W)) u_latency (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_req   (sync_req),
      .rise_nx    (rise_nx),
      .lat_in     (lat_sat),
      .first_data (first_data)
   );
endmodule

// File: rtl/mem_clk_gen_chk.sv
module mem_clk_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic sync_req,
   input logic mem_clk,
   input logic rise_stb,
   input logic fall_stb,
   input logic first_data
);
   AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> (mem_clk && !$past(mem_clk)));                  // R7
   AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |-> (!mem_clk && $past(mem_clk)));                  // R7
   AST_EDGE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_clk != $past(mem_clk)) |-> (rise_stb || fall_stb));     // R7
   AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_stb && fall_stb));                                    // R7
   AST_FD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      first_data |-> rise_stb);                                    // R8
   AST_FD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      first_data |=> !first_data);                                 // R8
   AST_FD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      first_data |-> $past(sync_req));                             // R10
endmodule

bind mem_clk_gen mem_clk_gen_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sync_req   (sync_req),
   .mem_clk    (mem_clk),
   .rise_stb   (rise_stb),
   .fall_stb   (fall_stb),
   .first_data (first_data)
);

// File: tb/mem_clk_gen_tb.sv
module mem_clk_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] div_ratio = 5'd4;
   logic [4:0] latency = 5'd2;
   logic       cont_en = 1'b0;
   logic       bank_sync = 1'b0;
   logic       sync_req = 1'b0;
   logic       mem_clk, rise_stb, fall_stb, first_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mem_clk_gen u_dut (
      .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .latency(latency),
      .cont_en(cont_en), .bank_sync(bank_sync), .sync_req(sync_req),
      .mem_clk(mem_clk), .rise_stb(rise_stb), .fall_stb(fall_stb),
      .first_data(first_data)
   );

   typedef struct packed {
      logic [4:0] div;
      logic [4:0] lat;
      logic       cont;
      logic       bank;
      logic [4:0] hi;
      logic [4:0] lo;
      logic [4:0] nlat;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{5'd2,  5'd2,  1'b0, 1'b0, 5'd1, 5'd1, 5'd2},
      '{5'd3,  5'd5,  1'b0, 1'b0, 5'd1, 5'd2, 5'd5},
      '{5'd4,  5'd2,  1'b0, 1'b0, 5'd2, 5'd2, 5'd2},
      '{5'd7,  5'd3,  1'b0, 1'b1, 5'd3, 5'd4, 5'd3},
      '{5'd16, 5'd17, 1'b0, 1'b0, 5'd8, 5'd8, 5'd17},
      '{5'd5,  5'd4,  1'b1, 1'b1, 5'd2, 5'd3, 5'd4},
      '{5'd0,  5'd0,  1'b0, 1'b0, 5'd1, 5'd1, 5'd2},
      '{5'd31, 5'd31, 1'b0, 1'b0, 5'd8, 5'd8, 5'd17},
      '{5'd9,  5'd1,  1'b1, 1'b0, 5'd4, 5'd5, 5'd2}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic go_idle();
      @(negedge clk);
      sync_req = 1'b0;
      cont_en  = 1'b0;
      repeat (40) @(negedge clk);
   endtask

   task automatic run_vec(input vec_t v);
      int  rises = 0, init_lo = 0, hi_len = 0, lo_len = 0;
      int  fd_cnt = 0, fd_at = -1, stb_bad = 0;
      bit  prev, seen_fall = 1'b0;
      @(negedge clk);
      div_ratio = v.div; latency = v.lat; cont_en = v.cont; bank_sync = v.bank;
      sync_req  = 1'b1;
      prev = mem_clk;
      for (int s = 0; s < 400 && rises < int'(v.nlat) + 2; s++) begin
         @(negedge clk);
         if (rise_stb !== (mem_clk && !prev)) stb_bad++;
         if (fall_stb !== (!mem_clk && prev)) stb_bad++;
         if (mem_clk && !prev) rises++;
         if (rises == 0 && !mem_clk) init_lo++;
         if (rises == 1 && mem_clk) hi_len++;
         if (!mem_clk && prev && rises == 1) seen_fall = 1'b1;
         if (seen_fall && rises == 1 && !mem_clk) lo_len++;
         if (first_data) begin
            fd_cnt++;
            fd_at = rises;
            if (!rise_stb) stb_bad++;
         end
         prev = mem_clk;
      end
      check(hi_len == int'(v.hi), "R5 high phase", hi_len, int'(v.hi));
      check(lo_len == int'(v.lo), "R5 low phase", lo_len, int'(v.lo));
      check(init_lo == int'(v.lo), "R5 start low", init_lo, int'(v.lo));
      check(stb_bad == 0, "R7 strobes", stb_bad, 0);
      check(fd_cnt == 1, "R8 single pulse", fd_cnt, 1);
      check(fd_at == int'(v.nlat) + 1, "R8 latency edge", fd_at, int'(v.nlat) + 1);
      go_idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int cnt, r;
      bit p;
      // R1: reset holds outputs low even with run requests present
      sync_req = 1'b1; cont_en = 1'b1; bank_sync = 1'b1;
      repeat (5) begin
         @(negedge clk);
         check({mem_clk, rise_stb, fall_stb, first_data} == 4'b0, "R1 reset",
               {mem_clk, rise_stb, fall_stb, first_data}, 0);
      end
      sync_req = 1'b0; cont_en = 1'b0; bank_sync = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R2: gated, no request -> clock stays low
      div_ratio = 5'd4; cnt = 0;
      repeat (50) begin @(negedge clk); if (mem_clk) cnt++; end
      check(cnt == 0, "R2 gated idle", cnt, 0);

      // R4: continuous without synchronous bank -> still idle
      cont_en = 1'b1; bank_sync = 1'b0; cnt = 0;
      repeat (50) begin @(negedge clk); if (mem_clk) cnt++; end
      check(cnt == 0, "R4 fallback", cnt, 0);

      // R3 and R10: free-running without request, no first_data
      bank_sync = 1'b1; cnt = 0; r = 0;
      repeat (50) begin
         @(negedge clk);
         if (rise_stb) cnt++;
         if (first_data) r++;
      end
      check(cnt >= 10, "R3 free run rises", cnt, 12);
      check(r == 0, "R10 no request", r, 0);
      go_idle();

      // R6: drop request right at a rising edge, full high phase then low
      div_ratio = 5'd6; bank_sync = 1'b0; sync_req = 1'b1;
      do @(negedge clk); while (!mem_clk);
      sync_req = 1'b0; cnt = 1;
      @(negedge clk);
      while (mem_clk) begin cnt++; @(negedge clk); end
      check(cnt == 3, "R6 full high phase", cnt, 3);
      cnt = 0;
      repeat (40) begin @(negedge clk); if (mem_clk) cnt++; end
      check(cnt == 0, "R6 stays low", cnt, 0);

      // R9: ratio change mid-period applies at next boundary
      div_ratio = 5'd4; sync_req = 1'b1;
      do @(negedge clk); while (!mem_clk);
      div_ratio = 5'd8; cnt = 1; p = 1'b1;
      @(negedge clk);
      while (mem_clk) begin cnt++; @(negedge clk); end
      check(cnt == 2, "R9 current period kept", cnt, 2);
      cnt = 0;
      while (!mem_clk) begin cnt++; @(negedge clk); end
      check(cnt == 4, "R9 new low phase", cnt, 4);
      cnt = 0;
      while (mem_clk) begin cnt++; @(negedge clk); end
      check(cnt == 4 && p, "R9 new high phase", cnt, 4);
      go_idle();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule